// File: doc/BRIEF.md
# Pipeline Hazard and Redirect Controller

This block is the control brain of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It receives only the register fields and control flags that sit in each stage register. From these it computes the operand forwarding selects for the instruction in decode, the stall and bubble controls, the flush controls for taken branches, the register-file write enable, and the choice of the next fetch address. The datapath, ALU, register-file storage and memories stay outside and use these signals.

Two kinds of redirect have different costs. Conditional branches are resolved in execute, so a taken branch squashes the two younger instructions already in flight. An unconditional jump is recognised in fetch, and its target is selected at once, so it costs no bubble. A terminating instruction stops further fetching. The pipeline then drains, and a sticky halt flag rises once that instruction retires from writeback.

Top module: `hzc_ctrl`

## Requirements
- R1: After synchronous reset, with all inputs low, pc_sel is 0 (sequential), every hold and kill output is 0 and halt is 0.
- R2: Each operand select fwd_sel[2i+1:2i] for source i is 1 (memory-stage result) when the memory-stage instruction writes a nonzero register equal to that source. Otherwise it is 2 (writeback result) when the writeback-stage instruction writes a nonzero register equal to it. Otherwise it is 0 (register file). The memory stage wins when both match.
- R3: Register 0 is never a forwarding source (the select for a source of 0 is always 0), and rf_we is high only when wb_reg_write is high and wb_rd is nonzero.
- R4: A load in execute that writes a nonzero register read by a used decode source causes a load-use stall. In that cycle hold_pc, hold_dec and kill_exe are 1, kill_dec is 0 and pc_sel is 3 (hold).
- R5: A taken branch in execute sets kill_dec and kill_exe, clears hold_pc and hold_dec and sets pc_sel to 2 (branch target). This takes precedence over a load-use stall, a jump and draining.
- R6: A jump in fetch, with no branch, stall, drain or terminator present, sets pc_sel to 1 (jump target) with no hold or kill.
- R7: A terminator in fetch, unless a branch or stall is present, gives pc_sel 3 in that cycle. From the next cycle on, the block drains: pc_sel stays 3 and kill_dec stays 1, even with a jump present.
- R8: A taken branch ends draining. In the following cycle, with idle inputs, pc_sel returns to 0 and kill_dec to 0.
- R9: halt rises in the cycle after wb_is_end is sampled high and stays high until reset.
- R10: No stall occurs when the load's destination is register 0, when the matching source is marked unused, when the execute instruction is not a load, or when the load does not write a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_is_jump | input | 1 | Fetched instruction is an unconditional jump |
| if_is_end | input | 1 | Fetched instruction is the terminator |
| id_src | input | NUM_SRC*REG_W | Decode source register numbers, source i at [i*REG_W +: REG_W] |
| id_src_used | input | NUM_SRC | Decode source i is actually read |
| ex_rd | input | REG_W | Execute destination register |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_branch_taken | input | 1 | Execute resolved a taken branch |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_W | Writeback destination register |
| wb_reg_write | input | 1 | Writeback instruction writes a register |
| wb_is_end | input | 1 | Terminator is retiring from writeback |
| pc_sel | output | 2 | Next PC: 0 sequential, 1 jump, 2 branch, 3 hold |
| hold_pc | output | 1 | Keep PC for a load-use stall |
| hold_dec | output | 1 | Keep the decode stage register |
| kill_dec | output | 1 | Load a bubble into the decode stage register |
| kill_exe | output | 1 | Load a bubble into the execute stage register |
| fwd_sel | output | 2*NUM_SRC | Operand select per source: 0 file, 1 memory, 2 writeback |
| rf_we | output | 1 | Register-file write enable after register-0 suppression |
| halt | output | 1 | Sticky halt after the terminator retires |

## Verification
Forwarding selects, rf_we, the stall, flush and kill outputs and pc_sel are combinational in the current stage fields. The bench therefore drives them just after a falling edge and samples them a few nanoseconds later, in the same cycle and before the next rising edge. The drain state and halt are registered one rising edge after their trigger: the terminator in fetch, a taken branch, or the terminator in writeback. Their checks are placed after that edge, and the value is also sampled before the edge to confirm it has not yet changed. Forwarding, register-0 suppression and load-use are swept over every combination of small register numbers and flags, and the expected values are worked out arithmetically.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    localparam int REG_W_MAX = 8;

    typedef enum logic [1:0] {
        PC_SEQ    = 2'd0,
        PC_JUMP   = 2'd1,
        PC_BRANCH = 2'd2,
        PC_HOLD   = 2'd3
    } pc_sel_e;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic hold_pc;
        logic hold_dec;
        logic kill_dec;
        logic kill_exe;
    } pipe_ctl_t;

    // A producer is a live bypass source for a consumer register when it
    // writes, targets a nonzero register and the numbers match.
    function automatic logic dest_hits(input logic we,
                                       input logic [REG_W_MAX-1:0] rd,
                                       input logic [REG_W_MAX-1:0] src);
        return we && (rd != '0) && (rd == src);
    endfunction

endpackage

// File: rtl/hzc_fwd_unit.sv
module hzc_fwd_unit
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             mem_we,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             wb_we,
    input  logic [REG_W-1:0] wb_rd,
    output fwd_sel_e         sel
);

    logic [REG_W_MAX-1:0] src_x, mem_x, wb_x;

    always_comb begin
        src_x = REG_W_MAX'(src);
        mem_x = REG_W_MAX'(mem_rd);
        wb_x  = REG_W_MAX'(wb_rd);
        if (dest_hits(mem_we, mem_x, src_x)) begin
            sel = FWD_MEM;
        end else if (dest_hits(wb_we, wb_x, src_x)) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_RF;
        end
    end

endmodule

// File: rtl/hzc_load_use.sv
module hzc_load_use
    import hzc_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*REG_W-1:0] src,
    input  logic [NUM_SRC-1:0]       used,
    input  logic                     ex_load,
    input  logic                     ex_we,
    input  logic [REG_W-1:0]         ex_rd,
    output logic                     stall
);

    logic [NUM_SRC-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign hit[i] = used[i] && ex_load &&
                dest_hits(ex_we, REG_W_MAX'(ex_rd),
                          REG_W_MAX'(src[i*REG_W +: REG_W]));
        end
    endgenerate

    assign stall = |hit;

endmodule

// File: rtl/hzc_redirect.sv
module hzc_redirect
    import hzc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      br_taken,
    input  logic      load_stall,
    input  logic      if_jump,
    input  logic      if_end,
    input  logic      wb_end,
    output pipe_ctl_t ctl,
    output pc_sel_e   pc_sel,
    output logic      halt
);

    logic draining_q;
    logic halt_q;

    // Priority: branch flush, then load-use stall, then drain, then fetch-side redirects.
    always_comb begin
        ctl    = '0;
        pc_sel = PC_SEQ;
        if (br_taken) begin
            ctl.kill_dec = 1'b1;
            ctl.kill_exe = 1'b1;
            pc_sel       = PC_BRANCH;
        end else if (load_stall) begin
            ctl.hold_pc  = 1'b1;
            ctl.hold_dec = 1'b1;
            ctl.kill_exe = 1'b1;
            pc_sel       = PC_HOLD;
        end else if (draining_q) begin
            ctl.kill_dec = 1'b1;
            pc_sel       = PC_HOLD;
        end else if (if_end) begin
            pc_sel = PC_HOLD;
        end else if (if_jump) begin
            pc_sel = PC_JUMP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            draining_q <= 1'b0;
            halt_q     <= 1'b0;
        end else begin
            if (br_taken) begin
                draining_q <= 1'b0;
            end else if (!load_stall && if_end) begin
                draining_q <= 1'b1;
            end
            if (wb_end) begin
                halt_q <= 1'b1;
            end
        end
    end

    assign halt = halt_q;

endmodule

// File: rtl/hzc_ctrl.sv
module hzc_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     if_is_jump,
    input  logic                     if_is_end,
    input  logic [NUM_SRC*REG_W-1:0] id_src,
    input  logic [NUM_SRC-1:0]       id_src_used,
    input  logic [REG_W-1:0]         ex_rd,
    input  logic                     ex_reg_write,
    input  logic                     ex_is_load,
    input  logic                     ex_branch_taken,
    input  logic [REG_W-1:0]         mem_rd,
    input  logic                     mem_reg_write,
    input  logic [REG_W-1:0]         wb_rd,
    input  logic                     wb_reg_write,
    input  logic                     wb_is_end,
    output logic [1:0]               pc_sel,
    output logic                     hold_pc,
    output logic                     hold_dec,
    output logic                     kill_dec,
    output logic                     kill_exe,
    output logic [2*NUM_SRC-1:0]     fwd_sel,
    output logic                     rf_we,
    output logic                     halt
);

    logic      load_stall;
    pipe_ctl_t ctl;
    pc_sel_e   pc_sel_w;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
            fwd_sel_e sel_w;
            hzc_fwd_unit #(.REG_W(REG_W)) u_fwd (
                .src    (id_src[i*REG_W +: REG_W]),
                .mem_we (mem_reg_write),
                .mem_rd (mem_rd),
                .wb_we  (wb_reg_write),
                .wb_rd  (wb_rd),
                .sel    (sel_w)
            );
            assign fwd_sel[2*i +: 2] = sel_w;
        end
    endgenerate

    hzc_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_lu (
        .src     (id_src),
        .used    (id_src_used),
        .ex_load (ex_is_load),
        .ex_we   (ex_reg_write),
        .ex_rd   (ex_rd),
        .stall   (load_stall)
    );

    hzc_redirect u_redir (
        .clk        (clk),
        .rst        (rst),
        .br_taken   (ex_branch_taken),
        .load_stall (load_stall),
        .if_jump    (if_is_jump),
        .if_end     (if_is_end),
        .wb_end     (wb_is_end),
        .ctl        (ctl),
        .pc_sel     (pc_sel_w),
        .halt       (halt)
    );

    assign pc_sel   = pc_sel_w;
    assign hold_pc  = ctl.hold_pc;
    assign hold_dec = ctl.hold_dec;
    assign kill_dec = ctl.kill_dec;
    assign kill_exe = ctl.kill_exe;
    assign rf_we    = wb_reg_write && (wb_rd != '0);

endmodule

// File: rtl/hzc_ctrl_chk.sv
module hzc_ctrl_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     if_is_jump,
    input logic                     if_is_end,
    input logic [NUM_SRC*REG_W-1:0] id_src,
    input logic [NUM_SRC-1:0]       id_src_used,
    input logic [REG_W-1:0]         ex_rd,
    input logic                     ex_reg_write,
    input logic                     ex_is_load,
    input logic                     ex_branch_taken,
    input logic [REG_W-1:0]         mem_rd,
    input logic                     mem_reg_write,
    input logic [REG_W-1:0]         wb_rd,
    input logic                     wb_reg_write,
    input logic                     wb_is_end,
    input logic [1:0]               pc_sel,
    input logic                     hold_pc,
    input logic                     hold_dec,
    input logic                     kill_dec,
    input logic                     kill_exe,
    input logic [2*NUM_SRC-1:0]     fwd_sel,
    input logic                     rf_we,
    input logic                     halt
);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            // R2: memory-stage match wins the operand select
            p_fwd_mem_first_r2: assert property (@(posedge clk) disable iff (rst)
                (mem_reg_write && mem_rd != '0 && mem_rd == id_src[i*REG_W +: REG_W])
                |-> fwd_sel[2*i +: 2] == 2'd1);
            // R3: register 0 never bypassed
            p_zero_src_r3: assert property (@(posedge clk) disable iff (rst)
                (id_src[i*REG_W +: REG_W] == '0) |-> fwd_sel[2*i +: 2] == 2'd0);
            // R4: load-use hazard stalls unless a branch is flushing
            p_load_use_r4: assert property (@(posedge clk) disable iff (rst)
                (ex_is_load && ex_reg_write && ex_rd != '0 && id_src_used[i] &&
                 ex_rd == id_src[i*REG_W +: REG_W] && !ex_branch_taken)
                |-> (hold_pc && hold_dec && kill_exe && !kill_dec && pc_sel == 2'd3));
        end
    endgenerate

    p_rf_we_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_rd == '0) |-> !rf_we);

    p_branch_flush_r5: assert property (@(posedge clk) disable iff (rst)
        ex_branch_taken |-> (kill_dec && kill_exe && !hold_pc && !hold_dec && pc_sel == 2'd2));

    p_jump_free_r6: assert property (@(posedge clk) disable iff (rst)
        (if_is_jump && !if_is_end && !ex_branch_taken && !hold_pc && !kill_dec)
        |-> pc_sel == 2'd1);

    p_drain_r7: assert property (@(posedge clk) disable iff (rst)
        (if_is_end && !ex_branch_taken && !hold_pc)
        |=> (ex_branch_taken || (pc_sel == 2'd3 && kill_dec)));

    p_halt_set_r9: assert property (@(posedge clk) disable iff (rst)
        wb_is_end |=> halt);

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

endmodule

bind hzc_ctrl hzc_ctrl_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .if_is_jump      (if_is_jump),
    .if_is_end       (if_is_end),
    .id_src          (id_src),
    .id_src_used     (id_src_used),
    .ex_rd           (ex_rd),
    .ex_reg_write    (ex_reg_write),
    .ex_is_load      (ex_is_load),
    .ex_branch_taken (ex_branch_taken),
    .mem_rd          (mem_rd),
    .mem_reg_write   (mem_reg_write),
    .wb_rd           (wb_rd),
    .wb_reg_write    (wb_reg_write),
    .wb_is_end       (wb_is_end),
    .pc_sel          (pc_sel),
    .hold_pc         (hold_pc),
    .hold_dec        (hold_dec),
    .kill_dec        (kill_dec),
    .kill_exe        (kill_exe),
    .fwd_sel         (fwd_sel),
    .rf_we           (rf_we),
    .halt            (halt)
);

// File: tb/tb_hzc_ctrl.sv
module tb_hzc_ctrl;

    localparam int REG_W   = 5;
    localparam int NUM_SRC = 2;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     if_is_jump, if_is_end;
    logic [NUM_SRC*REG_W-1:0] id_src;
    logic [NUM_SRC-1:0]       id_src_used;
    logic [REG_W-1:0]         ex_rd, mem_rd, wb_rd;
    logic                     ex_reg_write, ex_is_load, ex_branch_taken;
    logic                     mem_reg_write, wb_reg_write, wb_is_end;
    logic [1:0]               pc_sel;
    logic                     hold_pc, hold_dec, kill_dec, kill_exe, rf_we, halt;
    logic [2*NUM_SRC-1:0]     fwd_sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hzc_ctrl #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) dut (
        .clk(clk), .rst(rst), .if_is_jump(if_is_jump), .if_is_end(if_is_end),
        .id_src(id_src), .id_src_used(id_src_used), .ex_rd(ex_rd),
        .ex_reg_write(ex_reg_write), .ex_is_load(ex_is_load),
        .ex_branch_taken(ex_branch_taken), .mem_rd(mem_rd),
        .mem_reg_write(mem_reg_write), .wb_rd(wb_rd), .wb_reg_write(wb_reg_write),
        .wb_is_end(wb_is_end), .pc_sel(pc_sel), .hold_pc(hold_pc),
        .hold_dec(hold_dec), .kill_dec(kill_dec), .kill_exe(kill_exe),
        .fwd_sel(fwd_sel), .rf_we(rf_we), .halt(halt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        if_is_jump = 0; if_is_end = 0; id_src = '0; id_src_used = '0;
        ex_rd = '0; ex_reg_write = 0; ex_is_load = 0; ex_branch_taken = 0;
        mem_rd = '0; mem_reg_write = 0; wb_rd = '0; wb_reg_write = 0; wb_is_end = 0;
    endtask

    function automatic int exp_fwd(int s, int m, int mw, int w, int ww);
        if (mw != 0 && m != 0 && m == s) return 1;
        if (ww != 0 && w != 0 && w == s) return 2;
        return 0;
    endfunction

    // packed status: {hold_pc, hold_dec, kill_dec, kill_exe, pc_sel}
    function automatic int ctl_word(int hp, int hd, int kd, int ke, int ps);
        return (hp << 5) | (hd << 4) | (kd << 3) | (ke << 2) | ps;
    endfunction

    function automatic int got_ctl();
        return ctl_word(int'(hold_pc), int'(hold_dec), int'(kill_dec), int'(kill_exe), int'(pc_sel));
    endfunction

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        // R1 reset state
        check("R1 ctl", got_ctl(), 0);
        check("R1 halt", int'(halt), 0);
        @(negedge clk);
        check("R1 halt after edge", int'(halt), 0);

        // R2 / R3: forwarding sweep over small register numbers
        for (int s = 0; s < 8; s++)
            for (int m = 0; m < 8; m++)
                for (int w = 0; w < 8; w++)
                    for (int f = 0; f < 4; f++) begin
                        id_src = {REG_W'(7 - s), REG_W'(s)};
                        mem_rd = REG_W'(m); wb_rd = REG_W'(w);
                        mem_reg_write = f[0]; wb_reg_write = f[1];
                        #1;
                        check((s == 0) ? "R3 src0" : "R2 src0",
                              int'(fwd_sel[1:0]), exp_fwd(s, m, f[0], w, f[1]));
                        check((s == 7) ? "R3 src1" : "R2 src1",
                              int'(fwd_sel[3:2]), exp_fwd(7 - s, m, f[0], w, f[1]));
                    end
        // R3: write enable suppression
        for (int w = 0; w < 8; w++)
            for (int we = 0; we < 2; we++) begin
                wb_rd = REG_W'(w); wb_reg_write = we[0];
                #1;
                check("R3 rf_we", int'(rf_we), (we == 1 && w != 0) ? 1 : 0);
            end
        idle();

        // R4 / R10 / R5: load-use sweep, with and without a taken branch
        for (int br = 0; br < 2; br++)
            for (int e = 0; e < 8; e++)
                for (int a = 0; a < 4; a++)
                    for (int b = 0; b < 4; b++)
                        for (int fl = 0; fl < 16; fl++) begin
                            int stall;
                            id_src = {REG_W'(b), REG_W'(a)};
                            id_src_used = fl[1:0];
                            ex_is_load = fl[2]; ex_reg_write = fl[3];
                            ex_rd = REG_W'(e); ex_branch_taken = br[0];
                            #1;
                            stall = (fl[2] && fl[3] && e != 0 &&
                                     ((fl[0] && e == a) || (fl[1] && e == b))) ? 1 : 0;
                            if (br == 1)
                                check("R5 branch wins", got_ctl(), ctl_word(0, 0, 1, 1, 2));
                            else if (stall == 1)
                                check("R4 load-use", got_ctl(), ctl_word(1, 1, 0, 1, 3));
                            else
                                check("R10 no stall", got_ctl(), 0);
                        end
        idle();

        // R6: jump redirect, and stall overriding it
        @(negedge clk);
        if_is_jump = 1; #2;
        check("R6 jump", got_ctl(), ctl_word(0, 0, 0, 0, 1));
        ex_is_load = 1; ex_reg_write = 1; ex_rd = 5'd4;
        id_src = {5'd0, 5'd4}; id_src_used = 2'b01; #2;
        check("R4 stall over jump", got_ctl(), ctl_word(1, 1, 0, 1, 3));
        ex_branch_taken = 1; #2;
        check("R5 branch over stall and jump", got_ctl(), ctl_word(0, 0, 1, 1, 2));
        idle();

        // R7: terminator in fetch, then drain
        @(negedge clk);
        if_is_end = 1; #2;
        check("R7 end cycle", got_ctl(), ctl_word(0, 0, 0, 0, 3));
        @(negedge clk);
        idle(); #2;
        check("R7 draining", got_ctl(), ctl_word(0, 0, 1, 0, 3));
        if_is_jump = 1; #2;
        check("R7 jump ignored while draining", got_ctl(), ctl_word(0, 0, 1, 0, 3));
        @(negedge clk);
        idle(); #2;
        check("R7 still draining", got_ctl(), ctl_word(0, 0, 1, 0, 3));
        // R8: branch ends draining
        ex_branch_taken = 1; #2;
        check("R8 branch while draining", got_ctl(), ctl_word(0, 0, 1, 1, 2));
        @(negedge clk);
        idle(); #2;
        check("R8 drain cleared", got_ctl(), 0);
        // terminator during a stall does not start draining
        if_is_end = 1; ex_is_load = 1; ex_reg_write = 1; ex_rd = 5'd2;
        id_src = {5'd2, 5'd0}; id_src_used = 2'b10;
        @(negedge clk);
        idle(); #2;
        check("R7 no drain under stall", got_ctl(), 0);

        // R9: halt
        wb_is_end = 1; #2;
        check("R9 halt not before edge", int'(halt), 0);
        @(negedge clk);
        idle(); #2;
        check("R9 halt set", int'(halt), 1);
        repeat (3) @(negedge clk);
        check("R9 halt sticky", int'(halt), 1);
        rst = 1;
        @(negedge clk);
        rst = 0; #2;
        check("R1 halt cleared by reset", int'(halt), 0);
        check("R1 ctl after reset", got_ctl(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule